// File: doc/BRIEF.md
# Double-Buffered Display Configuration Registers

This block is the configuration register file of a display controller. Software reaches it over a simple 32-bit memory-mapped write/read port. It holds the panel timing words, the two panel sizes, the background and colour-key values, the line-interrupt number, the capability word and the graphics-layer setup: base addresses, position, size, FIFO threshold, row and pixel increments, and window skip. Each of these settings exists twice. Software writes a shadow copy. The pixel pipeline reads an active copy. The shadow set moves into the active set only when software sets one of the two commit bits in the control register. A frame can therefore never see a half-updated configuration.

The control word, the graphics attribute word and the interrupt registers are not double-buffered and take effect as soon as they are written. The block raises one interrupt line from a status/enable register pair. It also emits a one-cycle invalidate pulse whenever software touches a setting that changes the picture. Reads are combinational from the address. Register offsets are word addresses: index times four.

Top module: `disp_cfg_regs`

## Requirements
- R1: The control word (index 4) keeps only the bits of mask 0x07FF9FFF. Bit 0 drives `lcd_on` and bit 1 drives `dig_on`, from the clock edge that takes the write.
- R2: A write to a double-buffered register is readable at once and is masked to its field width: 24 bits for colours, 0x0FF0FF3F for the horizontal and vertical timing words. The matching `act_*` output keeps its old value until a commit.
- R3: Setting commit bit 5 or commit bit 6 of the control word copies the whole shadow set into the active set on the next clock edge. At that same edge the commit bits clear, so they read 1 for exactly one cycle.
- R4: Each size register (digital panel index 17, LCD panel index 18, layer index 22) has an 11-bit width field in bits 10:0 and an 11-bit height field in bits 26:16. The stored count is field+1. A read returns count-1. After reset every count is 1.
- R5: The graphics attribute word (index 23) keeps 11 bits and acts at once. Bit 0 drives `gfx_enable` and bits 4:1 drive `gfx_format`.
- R6: The config word (index 5) keeps 14 bits. On a `pal_loaded` pulse, a load-mode value of 1 in bits 2:1 becomes 0 and a value of 3 becomes 2, in both the shadow and active copies. The value 2 is left unchanged.
- R7: Writing ones to interrupt status (index 2) clears those bits, while writing zeros has no effect. `frame_done` sets status bit 0. Interrupt enable (index 3) keeps 16 bits. `irq` is high when any status bit and its enable bit are both set.
- R8: After reset the capability word (index 6) reads 0x161, and the row increment (index 25) and pixel increment (index 26) read 1. The line-status word (index 11) always reads 0x7FF and the reset-done word (index 1) always reads 1.
- R9: Writing bit 1 of the system word (index 0) returns every other register, shadow and active, to its reset value. The system word itself keeps mask 0x3019.
- R10: A write to a picture-affecting register drives `invalidate` high for exactly the cycle after the write. These registers are control, config, the colours, the sizes, base addresses, position, attribute, increments and the palette-table base. Writes to the window skip, threshold, timing, line number or capability registers leave it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| frame_done | input | 1 | Frame completed, sets status bit 0 |
| pal_loaded | input | 1 | Palette load finished |
| irq | output | 1 | Interrupt request |
| invalidate | output | 1 | Picture settings touched |
| lcd_on | output | 1 | LCD output enable |
| dig_on | output | 1 | Digital output enable |
| gfx_enable | output | 1 | Graphics layer enable |
| gfx_format | output | 4 | Graphics pixel format |
| act_config | output | 14 | Active config word |
| act_caps | output | 10 | Active capability word |
| act_bg_color0 | output | 24 | Active background colour 0 |
| act_bg_color1 | output | 24 | Active background colour 1 |
| act_key_color0 | output | 24 | Active colour key 0 |
| act_key_color1 | output | 24 | Active colour key 1 |
| act_line_num | output | 11 | Active line-interrupt number |
| act_htiming | output | 32 | Active horizontal timing |
| act_vtiming | output | 32 | Active vertical timing |
| act_polarity | output | 32 | Active polarity/frequency word |
| act_divisor | output | 32 | Active clock divisor word |
| act_dig_width | output | 12 | Active digital panel width (count) |
| act_dig_height | output | 12 | Active digital panel height (count) |
| act_lcd_width | output | 12 | Active LCD panel width (count) |
| act_lcd_height | output | 12 | Active LCD panel height (count) |
| act_gfx_base0 | output | 32 | Active graphics base address 0 |
| act_gfx_base1 | output | 32 | Active graphics base address 1 |
| act_gfx_table | output | 32 | Active palette table base |
| act_gfx_pos_x | output | 11 | Active layer X position |
| act_gfx_pos_y | output | 11 | Active layer Y position |
| act_gfx_width | output | 12 | Active layer width (count) |
| act_gfx_height | output | 12 | Active layer height (count) |
| act_gfx_thresh | output | 32 | Active FIFO thresholds |
| act_row_inc | output | 32 | Active row increment |
| act_pix_inc | output | 32 | Active pixel increment |
| act_win_skip | output | 32 | Active window skip |

## Verification
Each write is taken at the clock edge where `bus_we` is high. Immediate registers, shadow read-back, `invalidate` and the interrupt status therefore change one edge after the write or pulse, and active copies change one edge after that, when the commit bit is seen. The bench drives on falling edges and samples at the next falling edge for first-edge results. For commit results it samples twice: once at the first falling edge, to see the old active value and the pending commit bit, and once at the second, to see the copied value and the cleared commit bit. Read data is combinational, so it is sampled a delta after the address is set, away from any edge.

// File: rtl/disp_cfg_pkg.sv
// Shared widths, register indices, masks and the double-buffered set type.
// Assumes a 32-bit data bus and word-aligned register indices.
package disp_cfg_pkg;

    localparam int SZ_W   = 11;
    localparam int CNT_W  = SZ_W + 1;
    localparam int COL_W  = 24;
    localparam int CFG_W  = 14;
    localparam int CAP_W  = 10;
    localparam int IRQ_W  = 16;
    localparam int ATTR_W = 11;
    localparam int NREG   = 29;

    localparam int IX_SYS   = 0;
    localparam int IX_DONE  = 1;
    localparam int IX_ISTAT = 2;
    localparam int IX_IEN   = 3;
    localparam int IX_CTRL  = 4;
    localparam int IX_CFG   = 5;
    localparam int IX_CAPS  = 6;
    localparam int IX_BG0   = 7;
    localparam int IX_BG1   = 8;
    localparam int IX_KEY0  = 9;
    localparam int IX_KEY1  = 10;
    localparam int IX_LSTAT = 11;
    localparam int IX_LNUM  = 12;
    localparam int IX_TIMH  = 13;
    localparam int IX_TIMV  = 14;
    localparam int IX_POL   = 15;
    localparam int IX_DIV   = 16;
    localparam int IX_SZDIG = 17;
    localparam int IX_SZLCD = 18;
    localparam int IX_BA0   = 19;
    localparam int IX_BA1   = 20;
    localparam int IX_POS   = 21;
    localparam int IX_GSZ   = 22;
    localparam int IX_ATTR  = 23;
    localparam int IX_THR   = 24;
    localparam int IX_ROW   = 25;
    localparam int IX_PIX   = 26;
    localparam int IX_SKIP  = 27;
    localparam int IX_TBA   = 28;

    localparam logic [31:0] CTRL_MASK = 32'h07FF_9FFF;
    localparam logic [31:0] SYS_MASK  = 32'h0000_3019;
    localparam logic [31:0] TIM_MASK  = 32'h0FF0_FF3F;
    localparam logic [31:0] POL_MASK  = 32'h0003_FFFF;
    localparam logic [31:0] DIV_MASK  = 32'h00FF_00FF;
    localparam logic [31:0] THR_MASK  = 32'h01FF_01FF;
    localparam logic [CAP_W-1:0] CAPS_RST = CAP_W'(10'h161);
    localparam int GO_LCD_BIT = 5;
    localparam int GO_DIG_BIT = 6;

    // Registers whose write must request a redraw
    localparam logic [NREG-1:0] PICT_MASK =
        (NREG'(1) << IX_CTRL)  | (NREG'(1) << IX_CFG)   | (NREG'(1) << IX_BG0)  |
        (NREG'(1) << IX_BG1)   | (NREG'(1) << IX_KEY0)  | (NREG'(1) << IX_KEY1) |
        (NREG'(1) << IX_SZDIG) | (NREG'(1) << IX_SZLCD) | (NREG'(1) << IX_BA0)  |
        (NREG'(1) << IX_BA1)   | (NREG'(1) << IX_POS)   | (NREG'(1) << IX_GSZ)  |
        (NREG'(1) << IX_ATTR)  | (NREG'(1) << IX_ROW)   | (NREG'(1) << IX_PIX)  |
        (NREG'(1) << IX_TBA);

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic [CAP_W-1:0] caps;
        logic [COL_W-1:0] bg0;
        logic [COL_W-1:0] bg1;
        logic [COL_W-1:0] key0;
        logic [COL_W-1:0] key1;
        logic [SZ_W-1:0]  line;
        logic [31:0]      tim_h;
        logic [31:0]      tim_v;
        logic [31:0]      pol;
        logic [31:0]      div;
        logic [CNT_W-1:0] dig_w;
        logic [CNT_W-1:0] dig_h;
        logic [CNT_W-1:0] lcd_w;
        logic [CNT_W-1:0] lcd_h;
        logic [31:0]      ba0;
        logic [31:0]      ba1;
        logic [31:0]      tba;
        logic [SZ_W-1:0]  pos_x;
        logic [SZ_W-1:0]  pos_y;
        logic [CNT_W-1:0] gfx_w;
        logic [CNT_W-1:0] gfx_h;
        logic [31:0]      thr;
        logic [31:0]      row_inc;
        logic [31:0]      pix_inc;
        logic [31:0]      skip;
    } cfg_set_t;

    // Reset contents of a shadow or active set
    function automatic cfg_set_t cfg_set_reset();
        cfg_set_t s;
        s         = '0;
        s.caps    = CAPS_RST;
        s.dig_w   = CNT_W'(1);
        s.dig_h   = CNT_W'(1);
        s.lcd_w   = CNT_W'(1);
        s.lcd_h   = CNT_W'(1);
        s.gfx_w   = CNT_W'(1);
        s.gfx_h   = CNT_W'(1);
        s.row_inc = 32'd1;
        s.pix_inc = 32'd1;
        return s;
    endfunction

    // Load-mode settling after a palette load: 1 -> 0, 3 -> 2
    function automatic logic [CFG_W-1:0] pal_settle(input logic [CFG_W-1:0] c);
        logic [CFG_W-1:0] r;
        r = c;
        if (c[2:1] == 2'b01) r[2:1] = 2'b00;
        if (c[2:1] == 2'b11) r[2:1] = 2'b10;
        return r;
    endfunction

    // Biased size encoding
    function automatic logic [CNT_W-1:0] to_count(input logic [SZ_W-1:0] f);
        return CNT_W'({1'b0, f}) + CNT_W'(1);
    endfunction

    function automatic logic [SZ_W-1:0] to_field(input logic [CNT_W-1:0] c);
        return SZ_W'(c - CNT_W'(1));
    endfunction

endpackage

// File: rtl/disp_cfg_decode.sv
// Address decoder: turns a bus write into one-hot register strobes and
// flags writes that touch the picture. Assumes word-aligned addresses;
// unaligned or unmapped writes select nothing.
module disp_cfg_decode
    import disp_cfg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   wsel,
    output logic              pict_wr
);
    localparam int IW = ADDR_W - 2;

    // One comparator per register index
    for (genvar i = 0; i < NREG; i++) begin : g_sel
        assign wsel[i] = we && (addr[1:0] == 2'b00) && (addr[ADDR_W-1:2] == IW'(i));
    end

    // Redraw request for picture-affecting registers
    assign pict_wr = |(wsel & PICT_MASK);

endmodule

// File: rtl/disp_cfg_irq.sv
// Interrupt status/enable pair. Status bits are write-one-to-clear; the
// frame-done event sets bit 0 and wins over a same-cycle clear.
module disp_cfg_irq
    import disp_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             stat_wr,
    input  logic             en_wr,
    input  logic [IRQ_W-1:0] wdata,
    input  logic             frame_done,
    output logic [IRQ_W-1:0] stat_q,
    output logic [IRQ_W-1:0] en_q,
    output logic             irq
);
    logic [IRQ_W-1:0] clr;
    logic [IRQ_W-1:0] set;

    // Clear and set vectors for this cycle
    always_comb begin
        clr = stat_wr ? wdata : '0;
        set = {{(IRQ_W-1){1'b0}}, frame_done};
    end

    // Status register update
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) stat_q <= '0;
        else                    stat_q <= (stat_q & ~clr) | set;
    end

    // Enable register update
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) en_q <= '0;
        else if (en_wr)         en_q <= wdata;
    end

    // Request output
    assign irq = |(stat_q & en_q);

endmodule

// File: rtl/disp_cfg_bank.sv
// Shadow and active configuration sets plus the immediate registers
// (system, control, attribute). A pending commit bit copies the shadow
// set to the active set at the next edge and clears itself there.
// Assumes write strobes are one-hot.
module disp_cfg_bank
    import disp_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [NREG-1:0]   wsel,
    input  logic [31:0]       wdata,
    input  logic              pal_loaded,
    output cfg_set_t          shadow_q,
    output cfg_set_t          active_q,
    output logic [31:0]       ctrl_q,
    output logic [31:0]       sys_q,
    output logic [ATTR_W-1:0] attr_q,
    output logic              go_pending
);
    cfg_set_t sh_n;

    assign go_pending = ctrl_q[GO_LCD_BIT] | ctrl_q[GO_DIG_BIT];

    // Next shadow value: software writes, then palette settling
    always_comb begin
        sh_n = shadow_q;
        if (wsel[IX_CFG])   sh_n.cfg     = wdata[CFG_W-1:0];
        if (wsel[IX_CAPS])  sh_n.caps    = wdata[CAP_W-1:0];
        if (wsel[IX_BG0])   sh_n.bg0     = wdata[COL_W-1:0];
        if (wsel[IX_BG1])   sh_n.bg1     = wdata[COL_W-1:0];
        if (wsel[IX_KEY0])  sh_n.key0    = wdata[COL_W-1:0];
        if (wsel[IX_KEY1])  sh_n.key1    = wdata[COL_W-1:0];
        if (wsel[IX_LNUM])  sh_n.line    = wdata[SZ_W-1:0];
        if (wsel[IX_TIMH])  sh_n.tim_h   = wdata & TIM_MASK;
        if (wsel[IX_TIMV])  sh_n.tim_v   = wdata & TIM_MASK;
        if (wsel[IX_POL])   sh_n.pol     = wdata & POL_MASK;
        if (wsel[IX_DIV])   sh_n.div     = wdata & DIV_MASK;
        if (wsel[IX_SZDIG]) begin
            sh_n.dig_w = to_count(wdata[SZ_W-1:0]);
            sh_n.dig_h = to_count(wdata[16 +: SZ_W]);
        end
        if (wsel[IX_SZLCD]) begin
            sh_n.lcd_w = to_count(wdata[SZ_W-1:0]);
            sh_n.lcd_h = to_count(wdata[16 +: SZ_W]);
        end
        if (wsel[IX_BA0])   sh_n.ba0     = wdata;
        if (wsel[IX_BA1])   sh_n.ba1     = wdata;
        if (wsel[IX_TBA])   sh_n.tba     = wdata;
        if (wsel[IX_POS]) begin
            sh_n.pos_x = wdata[SZ_W-1:0];
            sh_n.pos_y = wdata[16 +: SZ_W];
        end
        if (wsel[IX_GSZ]) begin
            sh_n.gfx_w = to_count(wdata[SZ_W-1:0]);
            sh_n.gfx_h = to_count(wdata[16 +: SZ_W]);
        end
        if (wsel[IX_THR])   sh_n.thr     = wdata & THR_MASK;
        if (wsel[IX_ROW])   sh_n.row_inc = wdata;
        if (wsel[IX_PIX])   sh_n.pix_inc = wdata;
        if (wsel[IX_SKIP])  sh_n.skip    = wdata;
        if (pal_loaded)     sh_n.cfg     = pal_settle(sh_n.cfg);
    end

    // Shadow set register
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) shadow_q <= cfg_set_reset();
        else                    shadow_q <= sh_n;
    end

    // Active set: whole-set commit, otherwise palette settling only
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) active_q     <= cfg_set_reset();
        else if (go_pending)    active_q     <= sh_n;
        else if (pal_loaded)    active_q.cfg <= pal_settle(active_q.cfg);
    end

    // Control word: software write, else self-clearing commit bits
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) ctrl_q <= '0;
        else if (wsel[IX_CTRL]) ctrl_q <= wdata & CTRL_MASK;
        else if (go_pending) begin
            ctrl_q[GO_LCD_BIT] <= 1'b0;
            ctrl_q[GO_DIG_BIT] <= 1'b0;
        end
    end

    // Graphics attribute word, immediate
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) attr_q <= '0;
        else if (wsel[IX_ATTR]) attr_q <= wdata[ATTR_W-1:0];
    end

    // System word: survives its own soft reset
    always_ff @(posedge clk) begin
        if (!rst_n)            sys_q <= '0;
        else if (wsel[IX_SYS]) sys_q <= wdata & SYS_MASK;
    end

endmodule

// File: rtl/disp_cfg_regs.sv
// Top of the double-buffered display configuration register file.
// Decodes bus writes, keeps shadow/active sets and the interrupt pair,
// returns combinational read data and exports the active settings.
// Assumes one write per bus_we cycle and word-aligned addresses.
module disp_cfg_regs
    import disp_cfg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              frame_done,
    input  logic              pal_loaded,
    output logic              irq,
    output logic              invalidate,
    output logic              lcd_on,
    output logic              dig_on,
    output logic              gfx_enable,
    output logic [3:0]        gfx_format,
    output logic [13:0]       act_config,
    output logic [9:0]        act_caps,
    output logic [23:0]       act_bg_color0,
    output logic [23:0]       act_bg_color1,
    output logic [23:0]       act_key_color0,
    output logic [23:0]       act_key_color1,
    output logic [10:0]       act_line_num,
    output logic [31:0]       act_htiming,
    output logic [31:0]       act_vtiming,
    output logic [31:0]       act_polarity,
    output logic [31:0]       act_divisor,
    output logic [11:0]       act_dig_width,
    output logic [11:0]       act_dig_height,
    output logic [11:0]       act_lcd_width,
    output logic [11:0]       act_lcd_height,
    output logic [31:0]       act_gfx_base0,
    output logic [31:0]       act_gfx_base1,
    output logic [31:0]       act_gfx_table,
    output logic [10:0]       act_gfx_pos_x,
    output logic [10:0]       act_gfx_pos_y,
    output logic [11:0]       act_gfx_width,
    output logic [11:0]       act_gfx_height,
    output logic [31:0]       act_gfx_thresh,
    output logic [31:0]       act_row_inc,
    output logic [31:0]       act_pix_inc,
    output logic [31:0]       act_win_skip
);
    logic [NREG-1:0]   wsel;
    logic              pict_wr;
    logic              soft_rst;
    logic              go_pending;
    cfg_set_t          shadow_q;
    cfg_set_t          active_q;
    logic [31:0]       ctrl_q;
    logic [31:0]       sys_q;
    logic [ATTR_W-1:0] attr_q;
    logic [IRQ_W-1:0]  irq_stat;
    logic [IRQ_W-1:0]  irq_en;

    disp_cfg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .we      (bus_we),
        .addr    (bus_addr),
        .wsel    (wsel),
        .pict_wr (pict_wr)
    );

    assign soft_rst = wsel[IX_SYS] & bus_wdata[1];

    disp_cfg_bank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .wsel       (wsel),
        .wdata      (bus_wdata),
        .pal_loaded (pal_loaded),
        .shadow_q   (shadow_q),
        .active_q   (active_q),
        .ctrl_q     (ctrl_q),
        .sys_q      (sys_q),
        .attr_q     (attr_q),
        .go_pending (go_pending)
    );

    disp_cfg_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .stat_wr    (wsel[IX_ISTAT]),
        .en_wr      (wsel[IX_IEN]),
        .wdata      (bus_wdata[IRQ_W-1:0]),
        .frame_done (frame_done),
        .stat_q     (irq_stat),
        .en_q       (irq_en),
        .irq        (irq)
    );

    // Invalidate pulse, one cycle after a picture write
    always_ff @(posedge clk) begin
        if (!rst_n) invalidate <= 1'b0;
        else        invalidate <= pict_wr;
    end

    // Read-back multiplexer, software view (shadow copies)
    always_comb begin
        bus_rdata = '0;
        if (bus_addr[1:0] == 2'b00) begin
            case (int'(bus_addr[ADDR_W-1:2]))
                IX_SYS:   bus_rdata = sys_q;
                IX_DONE:  bus_rdata = 32'd1;
                IX_ISTAT: bus_rdata = 32'(irq_stat);
                IX_IEN:   bus_rdata = 32'(irq_en);
                IX_CTRL:  bus_rdata = ctrl_q;
                IX_CFG:   bus_rdata = 32'(shadow_q.cfg);
                IX_CAPS:  bus_rdata = 32'(shadow_q.caps);
                IX_BG0:   bus_rdata = 32'(shadow_q.bg0);
                IX_BG1:   bus_rdata = 32'(shadow_q.bg1);
                IX_KEY0:  bus_rdata = 32'(shadow_q.key0);
                IX_KEY1:  bus_rdata = 32'(shadow_q.key1);
                IX_LSTAT: bus_rdata = 32'({SZ_W{1'b1}});
                IX_LNUM:  bus_rdata = 32'(shadow_q.line);
                IX_TIMH:  bus_rdata = shadow_q.tim_h;
                IX_TIMV:  bus_rdata = shadow_q.tim_v;
                IX_POL:   bus_rdata = shadow_q.pol;
                IX_DIV:   bus_rdata = shadow_q.div;
                IX_SZDIG: begin
                    bus_rdata[SZ_W-1:0]    = to_field(shadow_q.dig_w);
                    bus_rdata[16 +: SZ_W]  = to_field(shadow_q.dig_h);
                end
                IX_SZLCD: begin
                    bus_rdata[SZ_W-1:0]    = to_field(shadow_q.lcd_w);
                    bus_rdata[16 +: SZ_W]  = to_field(shadow_q.lcd_h);
                end
                IX_BA0:   bus_rdata = shadow_q.ba0;
                IX_BA1:   bus_rdata = shadow_q.ba1;
                IX_POS: begin
                    bus_rdata[SZ_W-1:0]    = shadow_q.pos_x;
                    bus_rdata[16 +: SZ_W]  = shadow_q.pos_y;
                end
                IX_GSZ: begin
                    bus_rdata[SZ_W-1:0]    = to_field(shadow_q.gfx_w);
                    bus_rdata[16 +: SZ_W]  = to_field(shadow_q.gfx_h);
                end
                IX_ATTR:  bus_rdata = 32'(attr_q);
                IX_THR:   bus_rdata = shadow_q.thr;
                IX_ROW:   bus_rdata = shadow_q.row_inc;
                IX_PIX:   bus_rdata = shadow_q.pix_inc;
                IX_SKIP:  bus_rdata = shadow_q.skip;
                IX_TBA:   bus_rdata = shadow_q.tba;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // Immediate outputs
    assign lcd_on     = ctrl_q[0];
    assign dig_on     = ctrl_q[1];
    assign gfx_enable = attr_q[0];
    assign gfx_format = attr_q[4:1];

    // Active-set outputs
    assign act_config     = active_q.cfg;
    assign act_caps       = active_q.caps;
    assign act_bg_color0  = active_q.bg0;
    assign act_bg_color1  = active_q.bg1;
    assign act_key_color0 = active_q.key0;
    assign act_key_color1 = active_q.key1;
    assign act_line_num   = active_q.line;
    assign act_htiming    = active_q.tim_h;
    assign act_vtiming    = active_q.tim_v;
    assign act_polarity   = active_q.pol;
    assign act_divisor    = active_q.div;
    assign act_dig_width  = active_q.dig_w;
    assign act_dig_height = active_q.dig_h;
    assign act_lcd_width  = active_q.lcd_w;
    assign act_lcd_height = active_q.lcd_h;
    assign act_gfx_base0  = active_q.ba0;
    assign act_gfx_base1  = active_q.ba1;
    assign act_gfx_table  = active_q.tba;
    assign act_gfx_pos_x  = active_q.pos_x;
    assign act_gfx_pos_y  = active_q.pos_y;
    assign act_gfx_width  = active_q.gfx_w;
    assign act_gfx_height = active_q.gfx_h;
    assign act_gfx_thresh = active_q.thr;
    assign act_row_inc    = active_q.row_inc;
    assign act_pix_inc    = active_q.pix_inc;
    assign act_win_skip   = active_q.skip;

endmodule

// File: rtl/disp_cfg_regs_chk.sv
// Property checker for disp_cfg_regs, attached by bind below.
// Assumes the synchronous active-low reset of the top.
module disp_cfg_regs_chk
    import disp_cfg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic             soft_rst,
    input logic             go_pending,
    input logic [31:0]      act_htiming,
    input logic [31:0]      act_gfx_base0,
    input logic             frame_done,
    input logic [IRQ_W-1:0] irq_stat,
    input logic [IRQ_W-1:0] irq_en,
    input logic             irq,
    input logic             invalidate,
    input logic [11:0]      act_lcd_width,
    input logic [11:0]      act_gfx_width
);
    AST_GO_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (go_pending && !bus_we) |=> !go_pending); // R3

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!go_pending && !soft_rst) |=> ($stable(act_htiming) && $stable(act_gfx_base0))); // R2

    AST_SIZE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (act_lcd_width != 12'd0) && (act_gfx_width != 12'd0)); // R4

    AST_FRAME_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !soft_rst) |=> irq_stat[0]); // R7

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq); // R7

    AST_INVAL_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        invalidate |-> $past(bus_we)); // R10

endmodule

bind disp_cfg_regs disp_cfg_regs_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_we        (bus_we),
    .soft_rst      (soft_rst),
    .go_pending    (go_pending),
    .act_htiming   (act_htiming),
    .act_gfx_base0 (act_gfx_base0),
    .frame_done    (frame_done),
    .irq_stat      (irq_stat),
    .irq_en        (irq_en),
    .irq           (irq),
    .invalidate    (invalidate),
    .act_lcd_width (act_lcd_width),
    .act_gfx_width (act_gfx_width)
);

// File: tb/disp_cfg_regs_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module disp_cfg_regs_tb;

    localparam logic [7:0] A_SYS   = 8'h00;
    localparam logic [7:0] A_DONE  = 8'h04;
    localparam logic [7:0] A_ISTAT = 8'h08;
    localparam logic [7:0] A_IEN   = 8'h0C;
    localparam logic [7:0] A_CTRL  = 8'h10;
    localparam logic [7:0] A_CFG   = 8'h14;
    localparam logic [7:0] A_CAPS  = 8'h18;
    localparam logic [7:0] A_BG0   = 8'h1C;
    localparam logic [7:0] A_BG1   = 8'h20;
    localparam logic [7:0] A_LSTAT = 8'h2C;
    localparam logic [7:0] A_TIMH  = 8'h34;
    localparam logic [7:0] A_SZLCD = 8'h48;
    localparam logic [7:0] A_BA0   = 8'h4C;
    localparam logic [7:0] A_ATTR  = 8'h5C;
    localparam logic [7:0] A_ROW   = 8'h64;
    localparam logic [7:0] A_PIX   = 8'h68;
    localparam logic [7:0] A_SKIP  = 8'h6C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        frame_done = 1'b0;
    logic        pal_loaded = 1'b0;
    logic        irq, invalidate, lcd_on, dig_on, gfx_enable;
    logic [3:0]  gfx_format;
    logic [13:0] act_config;
    logic [9:0]  act_caps;
    logic [23:0] act_bg_color0, act_bg_color1, act_key_color0, act_key_color1;
    logic [10:0] act_line_num, act_gfx_pos_x, act_gfx_pos_y;
    logic [31:0] act_htiming, act_vtiming, act_polarity, act_divisor;
    logic [11:0] act_dig_width, act_dig_height, act_lcd_width, act_lcd_height;
    logic [11:0] act_gfx_width, act_gfx_height;
    logic [31:0] act_gfx_base0, act_gfx_base1, act_gfx_table, act_gfx_thresh;
    logic [31:0] act_row_inc, act_pix_inc, act_win_skip;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rv;

    always #10 clk = ~clk;

    disp_cfg_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_done(frame_done),
        .pal_loaded(pal_loaded), .irq(irq), .invalidate(invalidate),
        .lcd_on(lcd_on), .dig_on(dig_on), .gfx_enable(gfx_enable),
        .gfx_format(gfx_format), .act_config(act_config), .act_caps(act_caps),
        .act_bg_color0(act_bg_color0), .act_bg_color1(act_bg_color1),
        .act_key_color0(act_key_color0), .act_key_color1(act_key_color1),
        .act_line_num(act_line_num), .act_htiming(act_htiming),
        .act_vtiming(act_vtiming), .act_polarity(act_polarity),
        .act_divisor(act_divisor), .act_dig_width(act_dig_width),
        .act_dig_height(act_dig_height), .act_lcd_width(act_lcd_width),
        .act_lcd_height(act_lcd_height), .act_gfx_base0(act_gfx_base0),
        .act_gfx_base1(act_gfx_base1), .act_gfx_table(act_gfx_table),
        .act_gfx_pos_x(act_gfx_pos_x), .act_gfx_pos_y(act_gfx_pos_y),
        .act_gfx_width(act_gfx_width), .act_gfx_height(act_gfx_height),
        .act_gfx_thresh(act_gfx_thresh), .act_row_inc(act_row_inc),
        .act_pix_inc(act_pix_inc), .act_win_skip(act_win_skip)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Write one register; returns at the falling edge after the write edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    // Combinational read without waiting for a clock
    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        peek(a, d);
    endtask

    task automatic pulse_frame();
        @(negedge clk); frame_done = 1'b1;
        @(negedge clk); frame_done = 1'b0;
    endtask

    task automatic pulse_pal();
        @(negedge clk); pal_loaded = 1'b1;
        @(negedge clk); pal_loaded = 1'b0;
    endtask

    task automatic t_reset_state();
        rd(A_CAPS, rv);  chk("R8 caps reset", rv, 32'h161);
        rd(A_ROW, rv);   chk("R8 row inc reset", rv, 32'd1);
        rd(A_PIX, rv);   chk("R8 pixel inc reset", rv, 32'd1);
        rd(A_LSTAT, rv); chk("R8 line status", rv, 32'h7FF);
        rd(A_DONE, rv);  chk("R8 reset done", rv, 32'd1);
        rd(A_SZLCD, rv); chk("R4 size reads count-1 at reset", rv, 32'h0);
        chk("R4 active lcd width reset", 32'(act_lcd_width), 32'd1);
        chk("R8 irq low at reset", 32'(irq), 32'd0);
    endtask

    task automatic t_control();
        wr(A_CTRL, 32'hFFFF_FF9F);
        #1;
        chk("R1 lcd_on", 32'(lcd_on), 32'd1);
        chk("R1 dig_on", 32'(dig_on), 32'd1);
        rd(A_CTRL, rv); chk("R1 control mask", rv, 32'h07FF_9F9F);
        wr(A_CTRL, 32'h0000_0002);
        #1;
        chk("R1 lcd_on off", 32'(lcd_on), 32'd0);
        chk("R1 dig_on kept", 32'(dig_on), 32'd1);
    endtask

    task automatic t_shadow_commit();
        wr(A_BG0, 32'hFFAB_CDEF);
        rd(A_BG0, rv); chk("R2 bg0 shadow readback", rv, 32'h00AB_CDEF);
        chk("R2 bg0 active held", 32'(act_bg_color0), 32'h0);
        wr(A_TIMH, 32'hFFFF_FFFF);
        rd(A_TIMH, rv); chk("R2 timing mask", rv, 32'h0FF0_FF3F);
        chk("R2 timing active held", act_htiming, 32'h0);
        wr(A_CTRL, 32'h0000_0020);
        #1;
        chk("R3 active old before commit edge", 32'(act_bg_color0), 32'h0);
        peek(A_CTRL, rv); chk("R3 commit bit pending", rv, 32'h20);
        @(negedge clk); #1;
        chk("R3 bg0 committed", 32'(act_bg_color0), 32'h00AB_CDEF);
        chk("R3 timing committed", act_htiming, 32'h0FF0_FF3F);
        peek(A_CTRL, rv); chk("R3 commit bit cleared", rv, 32'h0);
        wr(A_BG1, 32'h0012_3456);
        wr(A_CTRL, 32'h0000_0040);
        @(negedge clk); #1;
        chk("R3 digital commit bg1", 32'(act_bg_color1), 32'h0012_3456);
    endtask

    task automatic t_sizes();
        wr(A_SZLCD, 32'hFFFF_FFFF);
        rd(A_SZLCD, rv); chk("R4 max size field", rv, 32'h07FF_07FF);
        wr(A_SZLCD, 32'h0010_0020);
        rd(A_SZLCD, rv); chk("R4 size readback", rv, 32'h0010_0020);
        wr(A_CTRL, 32'h0000_0020);
        @(negedge clk); #1;
        chk("R4 lcd width count", 32'(act_lcd_width), 32'h21);
        chk("R4 lcd height count", 32'(act_lcd_height), 32'h11);
    endtask

    task automatic t_attr();
        wr(A_ATTR, 32'hFFFF_FF0B);
        #1;
        chk("R5 gfx enable", 32'(gfx_enable), 32'd1);
        chk("R5 gfx format", 32'(gfx_format), 32'h5);
        rd(A_ATTR, rv); chk("R5 attr mask", rv, 32'h70B);
    endtask

    task automatic t_palette();
        wr(A_CFG, 32'h0000_4002);
        rd(A_CFG, rv); chk("R6 config 14 bits", rv, 32'h2);
        wr(A_CTRL, 32'h0000_0020);
        @(negedge clk); #1;
        chk("R6 config committed", 32'(act_config), 32'h2);
        pulse_pal();
        #1;
        chk("R6 mode1 active to 0", 32'(act_config), 32'h0);
        peek(A_CFG, rv); chk("R6 mode1 shadow to 0", rv, 32'h0);
        wr(A_CFG, 32'h0000_0006);
        wr(A_CTRL, 32'h0000_0040);
        @(negedge clk);
        pulse_pal();
        #1;
        chk("R6 mode3 active to 2", 32'(act_config), 32'h4);
        peek(A_CFG, rv); chk("R6 mode3 shadow to 2", rv, 32'h4);
        pulse_pal();
        #1;
        chk("R6 mode2 unchanged", 32'(act_config), 32'h4);
    endtask

    task automatic t_irq();
        wr(A_IEN, 32'hFFFF_FFFF);
        rd(A_IEN, rv); chk("R7 enable 16 bits", rv, 32'h0000_FFFF);
        pulse_frame();
        #1;
        chk("R7 irq raised", 32'(irq), 32'd1);
        peek(A_ISTAT, rv); chk("R7 status bit0 set", rv, 32'h1);
        wr(A_ISTAT, 32'h0);
        rd(A_ISTAT, rv); chk("R7 zero write no clear", rv, 32'h1);
        wr(A_ISTAT, 32'h1);
        #1;
        chk("R7 irq cleared", 32'(irq), 32'd0);
        wr(A_IEN, 32'h0);
        pulse_frame();
        #1;
        chk("R7 masked irq low", 32'(irq), 32'd0);
        peek(A_ISTAT, rv); chk("R7 masked status set", rv, 32'h1);
        wr(A_ISTAT, 32'h1);
    endtask

    task automatic t_invalidate();
        wr(A_SKIP, 32'h1234);
        #1;
        chk("R10 no pulse on skip write", 32'(invalidate), 32'd0);
        wr(A_BA0, 32'hCAFE_0000);
        #1;
        chk("R10 pulse on base write", 32'(invalidate), 32'd1);
        @(negedge clk); #1;
        chk("R10 pulse one cycle", 32'(invalidate), 32'd0);
    endtask

    task automatic t_soft_reset();
        wr(A_BG0, 32'h0055_5555);
        wr(A_CAPS, 32'h3);
        wr(A_CTRL, 32'h0000_0021);
        @(negedge clk);
        wr(A_SYS, 32'h0000_0003);
        #1;
        chk("R9 active bg0 reset", 32'(act_bg_color0), 32'h0);
        chk("R9 lcd_on reset", 32'(lcd_on), 32'd0);
        peek(A_SYS, rv); chk("R9 system word mask", rv, 32'h1);
        rd(A_BG0, rv);  chk("R9 shadow bg0 reset", rv, 32'h0);
        rd(A_CAPS, rv); chk("R9 caps back to reset", rv, 32'h161);
        rd(A_ATTR, rv); chk("R9 attr reset", rv, 32'h0);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Scenario sequence
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_control();
        t_shadow_commit();
        t_sizes();
        t_attr();
        t_palette();
        t_irq();
        t_invalidate();
        t_soft_reset();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule